// File: doc/BRIEF.md
# Match Timer with Watchdog Channel

This block is an operating-system timer with a free-running up-counter and four compare channels. Each channel holds a programmable compare value. When the counter equals that value, the channel's pending flag is set, and the flag drives an interrupt line if software has enabled that channel. Software reads and writes the block through a simple word-addressed register bus. Reads are combinational. Writes take effect at the clock edge.

The last compare channel can also serve as a watchdog. Once software sets the arm bit, only a hardware reset can disarm it. From then on, every compare hit on that channel produces a one-cycle system reset request, whatever that channel's interrupt enable is set to. To keep the system alive, software reads the counter and writes counter plus a margin into the watchdog compare register before the counter gets there. Because the compare is an exact equality, this works even when the sum wraps past the top of the counter range.

The watchdog is controlled by a three-state machine:
- OFF is the state after reset.
- ARMED is entered from OFF on a write of 1 to the arm bit (transition ARM).
- BITE is entered from ARMED on a hit of the watchdog channel (transition EXPIRE). BITE lasts one cycle and drives the reset request.
- BITE always returns to ARMED (transition RESUME).

Top module: `mtw_timer`

## Requirements
- R1: The counter reads 0 after reset, increments by one every clock cycle and wraps from 2^CNT_W-1 to 0. It is read at word offset 0x10, zero-extended, and writes to that offset have no effect.
- R2: Compare register n (n = 0..3) sits at offset 4*n. It resets to all ones and reads back the last value written, from bits CNT_W-1:0 of the write data.
- R3: Flag bit n of the status register at offset 0x14 (bits 3:0) becomes 1 on the clock edge that ends a cycle in which the counter equals compare register n.
- R4: A flag bit is cleared by writing 1 to its position in the status register. Writing 0 to a flag bit leaves it unchanged. A compare hit in the same cycle as a clear write leaves the flag set.
- R5: Interrupt output irq[n] is high exactly while flag n and enable bit n are both set. The enable bits are read/write at offset 0x1C, bits 3:0, and reset to 0.
- R6: Writing 1 to bit 0 at offset 0x18 arms the watchdog, and that bit then reads 1. Writes of 0 are ignored, so only reset disarms the watchdog.
- R7: While the watchdog is armed, a hit on channel 3 makes wdt_rst_req high for exactly one cycle. The pulse appears in the same cycle that flag 3 becomes 1, and it does not depend on enable bit 3.
- R8: While the watchdog is not armed, a channel 3 hit sets flag 3 but never raises wdt_rst_req.
- R9: Rewriting compare register 3 to the counter value plus a margin postpones the reset request. This includes margins for which the sum wraps past the top of the counter range.
- R10: A read of any word offset outside 0x00 to 0x1C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq | output | 4 | Per-channel interrupt lines |
| wdt_rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
Two events can fall in the same clock edge: a compare hit setting a flag, and a software write that clears that same flag. The bench sets the compare register to the counter value plus a known offset. It then counts cycles so that the clear write lands on the exact edge at which the hit is registered, and it expects the flag to read 1 afterwards. A second clear write, made with no hit present, must then read 0, which shows the clear path itself works. The watchdog pulse is judged the same way: the bench counts the cycles of the reset request from the refresh write and requires it to line up with flag 3 setting.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
    // number of compare channels; the last one doubles as the watchdog
    localparam int unsigned MTW_NCH  = 4;
    localparam int unsigned MTW_WDCH = MTW_NCH - 1;

    // word indices of the register offsets (byte offset / 4)
    localparam int unsigned IDX_CNT  = MTW_NCH;
    localparam int unsigned IDX_FLAG = MTW_NCH + 1;
    localparam int unsigned IDX_WDEN = MTW_NCH + 2;
    localparam int unsigned IDX_IEN  = MTW_NCH + 3;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_BITE  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/mtw_counter.sv
module mtw_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q
);
    // free-running, wraps naturally at the register width
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mtw_match_chan.sv
module mtw_match_chan #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] match_q,
    output logic             hit,
    output logic             flag_q
);
    // exact equality: wrap-safe, since counter+margin is taken modulo 2^CNT_W
    assign hit = (cnt == match_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '1;
        end else if (wr_en) begin
            match_q <= wdata;
        end
    end

    // a hit outranks a concurrent write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mtw_wd_fsm.sv
module mtw_wd_fsm
    import mtw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic expire,
    output logic armed,
    output logic bite
);
    wd_state_e state_q;
    wd_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ARM, EXPIRE, RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   if (arm_req) state_d = WD_ARMED;
            WD_ARMED: if (expire)  state_d = WD_BITE;
            WD_BITE:  state_d = WD_ARMED;
            default:  state_d = WD_OFF;
        endcase
    end

    // outputs
    always_comb begin
        armed = 1'b0;
        bite  = 1'b0;
        unique case (state_q)
            WD_OFF:   armed = 1'b0;
            WD_ARMED: armed = 1'b1;
            WD_BITE: begin
                armed = 1'b1;
                bite  = 1'b1;
            end
            default: armed = 1'b0;
        endcase
    end
endmodule

// File: rtl/mtw_timer.sv
module mtw_timer
    import mtw_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [MTW_NCH-1:0] irq,
    output logic              wdt_rst_req
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] W_CNT  = IDX_W'(IDX_CNT);
    localparam logic [IDX_W-1:0] W_FLAG = IDX_W'(IDX_FLAG);
    localparam logic [IDX_W-1:0] W_WDEN = IDX_W'(IDX_WDEN);
    localparam logic [IDX_W-1:0] W_IEN  = IDX_W'(IDX_IEN);

    logic [IDX_W-1:0]               word_idx;
    logic [CNT_W-1:0]               cnt_q;
    logic [MTW_NCH-1:0][CNT_W-1:0]  match_q;
    logic [MTW_NCH-1:0]             hit;
    logic [MTW_NCH-1:0]             flag_q;
    logic [MTW_NCH-1:0]             ien_q;
    logic                           wd_armed;
    logic                           wd_bite;
    logic                           arm_req;
    logic                           unused_bits;

    assign word_idx    = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    mtw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (cnt_q)
    );

    for (genvar i = 0; i < MTW_NCH; i++) begin : g_ch
        logic sel_wr;
        logic sel_clr;
        assign sel_wr  = bus_wr && (word_idx == IDX_W'(i));
        assign sel_clr = bus_wr && (word_idx == W_FLAG) && bus_wdata[i];

        mtw_match_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt_q),
            .wr_en   (sel_wr),
            .wdata   (bus_wdata[CNT_W-1:0]),
            .clr     (sel_clr),
            .match_q (match_q[i]),
            .hit     (hit[i]),
            .flag_q  (flag_q[i])
        );
    end

    // interrupt enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (bus_wr && (word_idx == W_IEN)) begin
            ien_q <= bus_wdata[MTW_NCH-1:0];
        end
    end

    assign irq = flag_q & ien_q;

    // watchdog: arm is one-way, bite is independent of the enable bits
    assign arm_req = bus_wr && (word_idx == W_WDEN) && bus_wdata[0];

    mtw_wd_fsm u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (arm_req),
        .expire  (hit[MTW_WDCH]),
        .armed   (wd_armed),
        .bite    (wd_bite)
    );

    assign wdt_rst_req = wd_bite;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (word_idx < IDX_W'(MTW_NCH)) begin
            bus_rdata = DATA_W'(match_q[word_idx[$clog2(MTW_NCH)-1:0]]);
        end else begin
            case (word_idx)
                W_CNT:   bus_rdata = DATA_W'(cnt_q);
                W_FLAG:  bus_rdata = DATA_W'(flag_q);
                W_WDEN:  bus_rdata = DATA_W'(wd_armed);
                W_IEN:   bus_rdata = DATA_W'(ien_q);
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mtw_timer_chk.sv
module mtw_timer_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned NCH   = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CNT_W-1:0]          cnt,
    input logic [NCH-1:0][CNT_W-1:0] match,
    input logic [NCH-1:0]            flag,
    input logic [NCH-1:0]            irq,
    input logic                      wd_en,
    input logic                      rst_req
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> cnt == CNT_W'($past(cnt) + 1'b1));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(cnt == match[i]) |-> flag[i]);
        a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> flag[i]);
    end

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(wd_en) |-> wd_en);

    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rst_req |-> $past(wd_en && (cnt == match[NCH-1])));

    a_r8_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> wd_en);
endmodule

bind mtw_timer mtw_timer_chk #(.CNT_W(CNT_W), .NCH(MTW_NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_q),
    .match   (match_q),
    .flag    (flag_q),
    .irq     (irq),
    .wd_en   (wd_armed),
    .rst_req (wdt_rst_req)
);

// File: tb/mtw_timer_tb.sv
module mtw_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_M0 = 6'h00, A_M1 = 6'h04, A_M2 = 6'h08, A_M3 = 6'h0C;
    localparam logic [5:0] A_CNT = 6'h10, A_FLAG = 6'h14, A_WDEN = 6'h18, A_IEN = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_b = 1'b0;
    logic        wr_s = 1'b0;
    logic [31:0] rdata_b, rdata_s;
    logic [3:0]  irq_b, irq_s;
    logic        req_b, req_s;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    bit wide = 1'b0;
    bit prev_req = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtw_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_b),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .irq(irq_b), .wdt_rst_req(req_b)
    );

    mtw_timer #(.CNT_W(8)) u_small (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_s),
        .bus_wdata(wdata), .bus_rdata(rdata_s), .irq(irq_s), .wdt_rst_req(req_s)
    );

    // pulse monitor on the large instance
    always @(negedge clk) begin
        if (req_b) n_pulse++;
        if (req_b && prev_req) wide = 1'b1;
        prev_req = req_b;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sm, input logic [5:0] a, input logic [31:0] d);
        addr = a;
        wdata = d;
        if (sm) wr_s = 1'b1; else wr_b = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_b = 1'b0;
        wr_s = 1'b0;
    endtask

    task automatic rd(input bit sm, input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = sm ? rdata_s : rdata_b;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v, c;
        rd(0, A_CNT, v);  chk("R1 counter after reset", v, 32'd0);
        rd(0, A_FLAG, v); chk("R3 flags after reset", v, 32'd0);
        rd(0, A_IEN, v);  chk("R5 enables after reset", v, 32'd0);
        rd(0, A_WDEN, v); chk("R6 arm bit after reset", v, 32'd0);
        rd(0, A_M2, v);   chk("R2 compare reset value", v, 32'hFFFF_FFFF);
        chk("R7 no request after reset", {31'd0, req_b}, 32'd0);
        rd(0, A_CNT, c);
        wait_cyc(5);
        rd(0, A_CNT, v);  chk("R1 counter step", v, c + 32'd5);
    endtask

    task automatic t_regs;
        logic [31:0] v, c;
        wr(0, A_M0, 32'h1234_5678);
        rd(0, A_M0, v); chk("R2 compare 0 readback", v, 32'h1234_5678);
        rd(0, A_CNT, c);
        wr(0, A_CNT, 32'd0);
        rd(0, A_CNT, v); chk("R1 counter write ignored", v, c + 32'd1);
        rd(0, 6'h20, v); chk("R10 unmapped read", v, 32'd0);
        rd(0, 6'h3C, v); chk("R10 unmapped read high", v, 32'd0);
    endtask

    task automatic t_match_irq;
        logic [31:0] v, c;
        rd(0, A_CNT, c);
        wr(0, A_M1, c + 32'd20);
        wait_cyc(19);
        rd(0, A_FLAG, v); chk("R3 flag 1 before hit", v & 32'h2, 32'd0);
        wait_cyc(1);
        rd(0, A_FLAG, v); chk("R3 flag 1 after hit", v & 32'h2, 32'h2);
        chk("R5 irq masked", {28'd0, irq_b}, 32'd0);
        wr(0, A_FLAG, 32'd0);
        rd(0, A_FLAG, v); chk("R4 write 0 keeps flag", v & 32'h2, 32'h2);
        wr(0, A_IEN, 32'h2);
        chk("R5 irq 1 raised", {28'd0, irq_b}, 32'h2);
        wr(0, A_FLAG, 32'h2);
        rd(0, A_FLAG, v); chk("R4 write 1 clears", v & 32'h2, 32'd0);
        chk("R5 irq 1 dropped", {28'd0, irq_b}, 32'd0);
    endtask

    task automatic t_clear_vs_hit;
        logic [31:0] v, c;
        rd(0, A_CNT, c);
        wr(0, A_M2, c + 32'd4);
        wait_cyc(4);
        rd(0, A_FLAG, v); chk("R3 flag 2 set", v & 32'h4, 32'h4);
        rd(0, A_CNT, c);
        wr(0, A_M2, c + 32'd4);
        wait_cyc(3);
        wr(0, A_FLAG, 32'h4);   // lands on the hit edge
        rd(0, A_FLAG, v); chk("R4 hit wins over clear", v & 32'h4, 32'h4);
        wr(0, A_FLAG, 32'h4);
        rd(0, A_FLAG, v); chk("R4 clear without hit", v & 32'h4, 32'd0);
    endtask

    task automatic t_unarmed;
        logic [31:0] v, c;
        int p0;
        p0 = n_pulse;
        rd(0, A_CNT, c);
        wr(0, A_M3, c + 32'd6);
        wait_cyc(6);
        rd(0, A_FLAG, v); chk("R8 flag 3 set unarmed", v & 32'h8, 32'h8);
        chk("R8 no request unarmed", n_pulse - p0, 0);
    endtask

    task automatic t_arm;
        logic [31:0] v;
        wr(0, A_WDEN, 32'd0);
        rd(0, A_WDEN, v); chk("R6 write 0 does not arm", v, 32'd0);
        wr(0, A_FLAG, 32'h8);
        wr(0, A_WDEN, 32'd1);
        rd(0, A_WDEN, v); chk("R6 armed", v, 32'd1);
        wr(0, A_WDEN, 32'd0);
        rd(0, A_WDEN, v); chk("R6 cannot disarm", v, 32'd1);
    endtask

    task automatic t_bite;
        logic [31:0] v, c;
        int p0;
        p0 = n_pulse;
        rd(0, A_CNT, c);
        wr(0, A_M3, c + 32'd10);
        wait_cyc(9);
        chk("R7 no request before hit", {31'd0, req_b}, 32'd0);
        wait_cyc(1);
        chk("R7 request pulse", {31'd0, req_b}, 32'd1);
        rd(0, A_FLAG, v); chk("R7 flag 3 same cycle", v & 32'h8, 32'h8);
        chk("R7 irq 3 still masked", {31'd0, irq_b[3]}, 32'd0);
        wait_cyc(1);
        chk("R7 request one cycle", {31'd0, req_b}, 32'd0);
        chk("R7 pulse count", n_pulse - p0, 1);
    endtask

    task automatic t_refresh;
        logic [31:0] c;
        int p0;
        p0 = n_pulse;
        for (int k = 0; k < 5; k++) begin
            rd(0, A_CNT, c);
            wr(0, A_M3, c + 32'd30);
            wait_cyc(20);
        end
        chk("R9 refresh postpones", n_pulse - p0, 0);
        rd(0, A_CNT, c);
        wr(0, A_M3, c + 32'd12);
        wait_cyc(11);
        chk("R9 quiet before final hit", {31'd0, req_b}, 32'd0);
        wait_cyc(1);
        chk("R9 request after refresh stops", {31'd0, req_b}, 32'd1);
        wait_cyc(1);
        chk("R9 one pulse", n_pulse - p0, 1);
        chk("R7 never wider than one cycle", {31'd0, wide}, 32'd0);
    endtask

    task automatic t_wrap;
        logic [31:0] c, v;
        int k;
        rd(1, A_CNT, c);
        k = (245 - int'(c)) & 255;
        if (k > 0) wait_cyc(k);
        rd(1, A_CNT, c); chk("R1 small counter positioned", c, 32'd245);
        wr(1, A_M3, (c + 32'd20) & 32'hFF);
        wr(1, A_WDEN, 32'd1);
        wait_cyc(18);
        chk("R9 wrap no early request", {31'd0, req_s}, 32'd0);
        wait_cyc(1);
        chk("R9 wrapped margin fires", {31'd0, req_s}, 32'd1);
        rd(1, A_CNT, v); chk("R1 counter wrapped", v, 32'd10);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_match_irq();
        t_clear_vs_hit();
        t_unarmed();
        t_arm();
        t_bite();
        t_refresh();
        t_wrap();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule